// File: doc/BRIEF.md
# Auto Data Rate Search Controller

This block is the slow control side of a serial video clock-recovery receiver. It picks the divider modulus and the oscillator band that the analog loop uses. It also steps the loop's frequency sweeps up and down until the loop reports phase lock. The block runs from a low-rate system clock with a nominal period of about 450 µs. This clock has no relation to the data rate. The phase-lock and data-present flags come from the analog side, so each one crosses into this clock domain through a two-flop synchronizer.

In automatic mode a 3-bit rate code walks through the legal codes 000 to 100. Each code gets one acquisition cycle: an upward sweep followed by a downward sweep. After that cycle the code moves on and wraps back to 000. The current code is reported on the status outputs. The standard-rate select changes how the codes map to a modulus and a band. In manual mode the code comes from input pins and is never changed by the search, while the sweeps repeat on the same setting.

Two conditions stop the sweeping and freeze the code:
- **Lock.** The code stays where it is until lock is lost while data is still present. The search then resumes from that code.
- **Loss of input data.** The code stays where it is, so reacquisition starts at the last rate that was in use.

The search state machine has four states:

| State | Meaning |
|---|---|
| HOLD | No data. Sweeping is stopped and the code is frozen. This is the state after reset. |
| UP | Upward sweep in progress. |
| DOWN | Downward sweep in progress. |
| LOCK | The loop is locked. Sweeping is stopped and the code is held. |

Its transitions are checked in this priority order:
1. Any state goes to HOLD when data is absent.
2. Otherwise, any state goes to LOCK when lock is present.
3. Otherwise, HOLD goes to UP and LOCK goes to UP.
4. UP goes to DOWN on the sweep-done strobe.
5. DOWN goes to UP on the sweep-done strobe. In automatic mode this DOWN to UP step also advances the code.

Top module: `rate_search_ctrl`

## Requirements
- R1: With std_sel high, codes 000, 001, 010, 011 and 100 give div_mod 4, 2, 2, 1 and 1. The band is H, L, H, L and H (band_low = 1 means band L). div_mod carries the modulus value itself.
- R2: With std_sel low, codes 000 and 001 give div_mod 4, codes 010 and 011 give div_mod 2, and code 100 gives div_mod 1. All of them use band H.
- R3: Code 101 gives div_mod 8 with std_sel high and 1 with std_sel low. Code 110 gives div_mod 8 for either std_sel. Code 111 is invalid and gives div_mod 0 on band H.
- R4: band_low is 1 only when std_sel is 1, code bit 0 is 1 and the code is valid.
- R5: sweep_dir reads 01 during an upward sweep, 10 during a downward sweep and 00 when stopped. Each acquisition cycle is an upward sweep, then a downward sweep, each ended by a sweep_done pulse. sweep_start is high for exactly one cycle at the start of each sweep.
- R6: In automatic mode, a downward sweep that ends without lock advances code_out by one. The code wraps from 100 to 000. code_out never shows a code above 100 in automatic mode; a code above 100 left over from manual mode reads as 000.
- R7: In manual mode, code_out equals man_code. Sweeps still alternate up and down, but the code never advances.
- R8: While lock is present and data is present, sweep_dir is 00 and code_out is held. Losing lock with data still present starts an upward sweep on the same code.
- R9: While data is absent, sweep_dir is 00 and code_out is frozen. When data returns, an upward sweep starts on the frozen code.
- R10: data_ok and pll_lock each pass through two synchronizing flops. A change on either one, applied between clock edges, first affects sweep_dir and sweep_start after the third rising edge that follows it.
- R11: During reset, sweep_dir is 00, sweep_start is 0, and code_out is 000 in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual code |
| std_sel | input | 1 | Standard-rate select; chooses the code table |
| man_code | input | 3 | Rate code used in manual mode |
| data_ok | input | 1 | Input data present (asynchronous) |
| pll_lock | input | 1 | Loop phase-locked (asynchronous) |
| sweep_done | input | 1 | One-cycle strobe marking the end of a sweep half |
| div_mod | output | 4 | Divider modulus value (1, 2, 4 or 8; 0 = invalid) |
| band_low | output | 1 | 1 = band L, 0 = band H |
| code_out | output | 3 | Current rate code |
| sweep_dir | output | 2 | 00 stopped, 01 up, 10 down |
| sweep_start | output | 1 | One-cycle pulse at the start of each sweep |

## Verification
The hardest situations to reach are the two frozen-code cases: a code held under lock, and a code held across loss of data. To reach them, the stimulus first walks the counter off 000 with pairs of sweep_done pulses. Only then does it raise lock or drop data, so that a wrongly reset or wrongly advancing code shows up as a wrong value. sweep_done pulses are then applied while the code is frozen, to prove they have no effect. The stimulus also parks an invalid manual code and then switches to automatic mode, to reach the clamp to 000. Synchronizer latency is checked by sampling on exactly the second and third falling edges after a flag changes.

// File: rtl/rate_search_pkg.sv
package rate_search_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned MOD_W  = 4;
    localparam logic [CODE_W-1:0] LAST_AUTO_CODE = 3'd4;

    typedef enum logic [1:0] {
        SWEEP_OFF  = 2'b00,
        SWEEP_UP   = 2'b01,
        SWEEP_DOWN = 2'b10
    } sweep_dir_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_UP,
        ST_DOWN,
        ST_LOCK
    } search_st_e;

endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rs_rate_map.sv
module rs_rate_map
    import rate_search_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              std_sel,
    output logic [MOD_W-1:0]  div_mod_o,
    output logic              band_low_o
);

    always_comb begin
        div_mod_o  = '0;
        band_low_o = 1'b0;
        unique case (code_i)
            3'b000: begin div_mod_o = 4'd4; band_low_o = 1'b0; end
            3'b001: begin div_mod_o = std_sel ? 4'd2 : 4'd4; band_low_o = std_sel; end
            3'b010: begin div_mod_o = 4'd2; band_low_o = 1'b0; end
            3'b011: begin div_mod_o = std_sel ? 4'd1 : 4'd2; band_low_o = std_sel; end
            3'b100: begin div_mod_o = 4'd1; band_low_o = 1'b0; end
            3'b101: begin div_mod_o = std_sel ? 4'd8 : 4'd1; band_low_o = std_sel; end
            3'b110: begin div_mod_o = 4'd8; band_low_o = 1'b0; end
            default: begin div_mod_o = '0; band_low_o = 1'b0; end
        endcase
    end

    // R4: band L needs the standard select and code bit 0 together
    always_comb begin
        if (band_low_o) begin
            a_r4_band_low: assert (std_sel && code_i[0])
                else $error("band L selected without std_sel and code bit 0");
        end
        // R3: every modulus value is a single power of two or the invalid zero
        a_r3_mod_form: assert ($onehot0(div_mod_o))
            else $error("modulus value is not a single power of two");
    end

endmodule

// File: rtl/rs_code_counter.sv
module rs_code_counter
    import rate_search_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_mode,
    input  logic [CODE_W-1:0] man_code,
    input  logic              advance,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] legal_c;
    logic [CODE_W-1:0] next_c;

    always_comb begin
        legal_c = (code_q > LAST_AUTO_CODE) ? '0 : code_q;
        if (!auto_mode) begin
            next_c = man_code;
        end else if (advance) begin
            next_c = (legal_c == LAST_AUTO_CODE) ? '0 : legal_c + 1'b1;
        end else begin
            next_c = legal_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= next_c;
        end
    end

    assign code_o = auto_mode ? legal_c : man_code;

    // R6: automatic mode only presents searchable codes
    a_r6_auto_legal: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode |-> (code_o <= LAST_AUTO_CODE))
        else $error("automatic mode presented an unsearchable code");

    // R6: the last searchable code wraps to zero on advance
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && $past(auto_mode) && $past(advance)
         && ($past(code_o) == LAST_AUTO_CODE)) |-> (code_o == '0))
        else $error("code did not wrap after the last searchable code");

endmodule

// File: rtl/rs_search_fsm.sv
module rs_search_fsm
    import rate_search_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       data_s,
    input  logic       lock_s,
    input  logic       sweep_done,
    output logic [1:0] sweep_dir,
    output logic       sweep_start,
    output logic       advance,
    output logic       locked
);

    search_st_e state_q;
    search_st_e state_n;
    logic       start_q;
    logic       start_n;

    always_comb begin
        state_n = state_q;
        advance = 1'b0;
        if (!data_s) begin
            state_n = ST_HOLD;
        end else if (lock_s) begin
            state_n = ST_LOCK;
        end else begin
            unique case (state_q)
                ST_HOLD: state_n = ST_UP;
                ST_LOCK: state_n = ST_UP;
                ST_UP: begin
                    if (sweep_done) state_n = ST_DOWN;
                end
                ST_DOWN: begin
                    if (sweep_done) begin
                        state_n = ST_UP;
                        advance = auto_mode;
                    end
                end
                default: state_n = ST_HOLD;
            endcase
        end
        start_n = ((state_n == ST_UP)   && (state_q != ST_UP)) ||
                  ((state_n == ST_DOWN) && (state_q != ST_DOWN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            start_q <= 1'b0;
        end else begin
            state_q <= state_n;
            start_q <= start_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_UP:   sweep_dir = SWEEP_UP;
            ST_DOWN: sweep_dir = SWEEP_DOWN;
            default: sweep_dir = SWEEP_OFF;
        endcase
        sweep_start = start_q;
        locked      = (state_q == ST_LOCK);
    end

    // R5: a start pulse always comes with an active sweep direction
    a_r5_start_dir: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_start |-> (sweep_dir != SWEEP_OFF))
        else $error("start pulse without a sweep direction");

    // R9: missing data in the previous cycle stops the sweep
    a_r9_nodata_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!data_s) |-> (sweep_dir == SWEEP_OFF))
        else $error("sweep running without input data");

    // R8: lock with data in the previous cycle stops the sweep
    a_r8_lock_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_s && data_s) |-> (sweep_dir == SWEEP_OFF && !sweep_start))
        else $error("sweep running while locked");

endmodule

// File: rtl/rate_search_ctrl.sv
module rate_search_ctrl
    import rate_search_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_mode,
    input  logic              std_sel,
    input  logic [CODE_W-1:0] man_code,
    input  logic              data_ok,
    input  logic              pll_lock,
    input  logic              sweep_done,
    output logic [MOD_W-1:0]  div_mod,
    output logic              band_low,
    output logic [CODE_W-1:0] code_out,
    output logic [1:0]        sweep_dir,
    output logic              sweep_start
);

    localparam int unsigned FLAG_W = 2;

    logic [FLAG_W-1:0] flags_s;
    logic              data_s;
    logic              lock_s;
    logic              advance;
    logic              locked;

    rs_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pll_lock, data_ok}),
        .sync_o  (flags_s)
    );

    assign data_s = flags_s[0];
    assign lock_s = flags_s[1];

    rs_search_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mode   (auto_mode),
        .data_s      (data_s),
        .lock_s      (lock_s),
        .sweep_done  (sweep_done),
        .sweep_dir   (sweep_dir),
        .sweep_start (sweep_start),
        .advance     (advance),
        .locked      (locked)
    );

    rs_code_counter u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_mode (auto_mode),
        .man_code  (man_code),
        .advance   (advance),
        .code_o    (code_out)
    );

    rs_rate_map u_map (
        .code_i     (code_out),
        .std_sel    (std_sel),
        .div_mod_o  (div_mod),
        .band_low_o (band_low)
    );

    // R9: the code does not move while data was absent
    a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && $past(auto_mode) && $past(!data_s)) |-> $stable(code_out))
        else $error("code moved while data was absent");

    // R8: the code does not move while the loop stays locked
    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && $past(auto_mode) && $past(locked) && locked) |-> $stable(code_out))
        else $error("code moved while locked");

    // R6: automatic mode never selects the manual-only moduli or an invalid one
    a_r6_auto_mod: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode |-> (div_mod != 4'd0 && div_mod != 4'd8))
        else $error("automatic mode selected a manual-only modulus");

endmodule

// File: tb/tb_rate_search_ctrl.sv
module tb_rate_search_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic       std_sel = 1'b1;
    logic [2:0] man_code = 3'b000;
    logic       data_ok = 1'b1;
    logic       pll_lock = 1'b0;
    logic       sweep_done = 1'b0;
    logic [3:0] div_mod;
    logic       band_low;
    logic [2:0] code_out;
    logic [1:0] sweep_dir;
    logic       sweep_start;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    localparam logic [1:0] D_OFF = 2'b00, D_UP = 2'b01, D_DN = 2'b10;

    // {std_sel, code, expected modulus, expected band_low}
    localparam logic [8:0] MAP_VEC [0:15] = '{
        9'b1_000_0100_0, 9'b1_001_0010_1, 9'b1_010_0010_0, 9'b1_011_0001_1,
        9'b1_100_0001_0, 9'b1_101_1000_1, 9'b1_110_1000_0, 9'b1_111_0000_0,
        9'b0_000_0100_0, 9'b0_001_0100_0, 9'b0_010_0010_0, 9'b0_011_0010_0,
        9'b0_100_0001_0, 9'b0_101_0001_0, 9'b0_110_1000_0, 9'b0_111_0000_0
    };

    rate_search_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mode   (auto_mode),
        .std_sel     (std_sel),
        .man_code    (man_code),
        .data_ok     (data_ok),
        .pll_lock    (pll_lock),
        .sweep_done  (sweep_done),
        .div_mod     (div_mod),
        .band_low    (band_low),
        .code_out    (code_out),
        .sweep_dir   (sweep_dir),
        .sweep_start (sweep_start)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic done_pulse();
        sweep_done = 1'b1;
        @(negedge clk);
        sweep_done = 1'b0;
    endtask

    function automatic logic [3:0] exp_mod(input logic s, input logic [2:0] c);
        case (c)
            3'd0: return 4'd4;
            3'd1: return s ? 4'd2 : 4'd4;
            3'd2: return 4'd2;
            3'd3: return s ? 4'd1 : 4'd2;
            3'd4: return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    function automatic string map_tag(input logic [2:0] c, input logic s);
        if (c > 3'd4) return "R3";
        return s ? "R1" : "R2";
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fail++;
                $display("FAIL R5 watchdog actual=timeout expected=finished");
                report();
            end
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", "dir in reset", 8'(sweep_dir), 8'(D_OFF));
        chk("R11", "start in reset", 8'(sweep_start), 8'd0);
        chk("R11", "code in reset", 8'(code_out), 8'd0);
        rst_n = 1'b1;

        // R10: data flag needs three edges to start the sweep
        @(negedge clk);
        chk("R10", "dir after 1 edge", 8'(sweep_dir), 8'(D_OFF));
        @(negedge clk);
        chk("R10", "dir after 2 edges", 8'(sweep_dir), 8'(D_OFF));
        @(negedge clk);
        chk("R10", "start after 3 edges", 8'(sweep_start), 8'd1);
        chk("R5", "first sweep up", 8'(sweep_dir), 8'(D_UP));
        @(negedge clk);
        chk("R5", "start is one cycle", 8'(sweep_start), 8'd0);

        // R5 R6: five codes walked with std_sel high, then wrap
        for (int i = 1; i <= 5; i++) begin
            done_pulse();
            chk("R5", "down half", 8'(sweep_dir), 8'(D_DN));
            chk("R5", "start on down", 8'(sweep_start), 8'd1);
            done_pulse();
            chk("R6", "advanced code", 8'(code_out), 8'(i % 5));
            chk("R5", "up half", 8'(sweep_dir), 8'(D_UP));
        end

        // R2 R6: std_sel low walk
        std_sel = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            done_pulse();
            done_pulse();
            chk("R6", "std0 code", 8'(code_out), 8'(i % 5));
            chk("R2", "std0 modulus", 8'(div_mod), 8'(exp_mod(1'b0, 3'(i % 5))));
            chk("R2", "std0 band", 8'(band_low), 8'd0);
        end
        std_sel = 1'b1;

        // R8: lock holds code 001
        done_pulse();
        done_pulse();
        chk("R6", "code before lock", 8'(code_out), 8'd1);
        pll_lock = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "lock not yet seen", 8'(sweep_dir), 8'(D_UP));
        @(negedge clk);
        chk("R8", "locked stops sweep", 8'(sweep_dir), 8'(D_OFF));
        for (int i = 0; i < 4; i++) done_pulse();
        chk("R8", "locked code held", 8'(code_out), 8'd1);
        chk("R8", "locked no start", 8'(sweep_start), 8'd0);
        pll_lock = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "relock start", 8'(sweep_start), 8'd1);
        chk("R8", "relock dir up", 8'(sweep_dir), 8'(D_UP));
        chk("R8", "relock same code", 8'(code_out), 8'd1);

        // R9: data loss freezes code
        done_pulse();
        chk("R5", "down before loss", 8'(sweep_dir), 8'(D_DN));
        data_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "no data stops sweep", 8'(sweep_dir), 8'(D_OFF));
        for (int i = 0; i < 4; i++) done_pulse();
        chk("R9", "code frozen", 8'(code_out), 8'd1);
        data_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "resume start", 8'(sweep_start), 8'd1);
        chk("R9", "resume up", 8'(sweep_dir), 8'(D_UP));
        chk("R9", "resume code", 8'(code_out), 8'd1);

        // R1 R2 R3 R4: table walk in manual mode
        auto_mode = 1'b0;
        for (int i = 0; i < 16; i++) begin
            std_sel  = MAP_VEC[i][8];
            man_code = MAP_VEC[i][7:5];
            @(negedge clk);
            chk(map_tag(MAP_VEC[i][7:5], MAP_VEC[i][8]), "modulus",
                8'(div_mod), 8'(MAP_VEC[i][4:1]));
            chk("R4", "band", 8'(band_low), 8'(MAP_VEC[i][0]));
        end

        // R7: manual code is never advanced
        std_sel  = 1'b1;
        man_code = 3'b110;
        @(negedge clk);
        chk("R7", "manual code out", 8'(code_out), 8'h6);
        for (int i = 0; i < 6; i++) done_pulse();
        chk("R7", "manual code after cycles", 8'(code_out), 8'h6);
        chk("R7", "manual modulus", 8'(div_mod), 8'd8);
        done_pulse();
        chk("R7", "manual sweeps continue", 8'(sweep_dir), 8'(D_DN));
        man_code = 3'b101;
        @(negedge clk);
        chk("R7", "manual 101 band L", 8'(band_low), 8'd1);

        // R6: leftover manual code reads as 000 in auto mode
        auto_mode = 1'b1;
        @(negedge clk);
        chk("R6", "clamped code", 8'(code_out), 8'd0);
        chk("R6", "clamped modulus", 8'(div_mod), 8'd4);
        done_pulse();
        chk("R6", "advance after clamp", 8'(code_out), 8'd1);

        report();
    end

endmodule